// File: doc/BRIEF.md
# Segmented Binary Counter with Registered Section Carries

This block is a wide, free-running synchronous up-counter that keeps high clock rates by splitting the count into equal sections. The carry from each section into the one above is a flip-flop, so no combinational carry chain is longer than one section. That flip-flop is set one cycle before the section below it becomes all ones. Each upper section therefore steps on exactly the cycle a plain binary counter of the same width would step it.

The counter has one enable. While the enable is low, every section and every carry flop holds. A registered terminal-count flag shows when the whole count is all ones. The next enabled cycle wraps the count to zero. A synchronous reset clears all of the state at once. The default build is four sections of 8 bits (32 bits in total). Both the section width and the number of sections are parameters.

Top module: `seg_counter`

## Requirements
- R1: One cycle after a clock edge with `rst` high, `count_q` is zero and `term_cnt` is low, whatever `cnt_en` was.
- R2: On each clock edge with `rst` low and `cnt_en` high, `count_q` becomes its previous value plus one, modulo 2^(SEG_W*SEGS).
- R3: On a clock edge with `rst` low and `cnt_en` low, `count_q` and `term_cnt` keep their values.
- R4: A section above the lowest one steps on the enabled edge where every bit below it is one, and on no other edge. The sequence stays identical to a plain binary counter across every section boundary.
- R5: `term_cnt` is high in exactly those cycles in which every bit of `count_q` is one.
- R6: An enabled edge taken while `count_q` is all ones makes `count_q` zero and drops `term_cnt`.
- R7: Reset takes priority over enable. A reset edge while counting with `cnt_en` high still gives zero, and counting restarts from zero on the next enabled edge.
- R8: Dropping `cnt_en` for any number of cycles loses no carry and duplicates none. This includes the cycle in which a lower section has just reached all ones or the whole count is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, active high |
| count_q | output | SEG_W*SEGS | Current binary count |
| term_cnt | output | 1 | High while the count is all ones |

## Verification
The hardest case to reach from the ports is the carry into the top section and the full wrap. There is no load input, and the default 32-bit count needs about four billion enabled cycles to wrap. The bench therefore runs a second instance with 3-bit sections and a 12-bit total. This instance wraps in a few thousand cycles, while the default instance covers the low section boundaries. On both instances, random enable gaps and scripted pauses are placed exactly on the cycle where a lower section, or the whole count, has just reached all ones. These pauses test the case where an early-set carry flop must hold through the gap.

// File: rtl/seg_cnt_pkg.sv
package seg_cnt_pkg;

  localparam int unsigned MAX_SEG_W = 64;

  // True when the low w bits of v are all ones.
  function automatic logic seg_full(input logic [MAX_SEG_W-1:0] v, input int unsigned w);
    logic [MAX_SEG_W-1:0] mask;
    mask = (w >= MAX_SEG_W) ? '1 : ((64'd1 << w) - 64'd1);
    return (v & mask) == mask;
  endfunction

  // True when the low w bits of v equal all ones minus one.
  function automatic logic seg_pre_full(input logic [MAX_SEG_W-1:0] v, input int unsigned w);
    logic [MAX_SEG_W-1:0] mask;
    mask = (w >= MAX_SEG_W) ? '1 : ((64'd1 << w) - 64'd1);
    return (v & mask) == (mask - 64'd1);
  endfunction

endpackage

// File: rtl/seg_cnt_section.sv
module seg_cnt_section #(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             carry_in,
  output logic [SEG_W-1:0] val,
  output logic             at_full,
  output logic             at_pre_full
);
  import seg_cnt_pkg::*;

  logic step;

  assign step        = en && carry_in;
  assign at_full     = seg_full(seg_cnt_pkg::MAX_SEG_W'(val), SEG_W);
  assign at_pre_full = seg_pre_full(seg_cnt_pkg::MAX_SEG_W'(val), SEG_W);

  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (step) val <= val + 1'b1;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    step |=> (val == SEG_W'($past(val) + 1'b1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(val));

endmodule

// File: rtl/seg_cnt_carry.sv
module seg_cnt_carry (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic chain_in,
  input  logic local_ok,
  output logic carry_d,
  output logic carry_q
);

  // Early set: the carry flop takes the value "all bits below are ones"
  // that will hold after this edge.
  assign carry_d = en ? (chain_in && local_ok) : carry_q;

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= carry_d;
  end

  p_carry_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(carry_q));

endmodule

// File: rtl/seg_counter.sv
module seg_counter #(
  parameter int unsigned SEG_W = 8,
  parameter int unsigned SEGS  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cnt_en,
  output logic [SEG_W*SEGS-1:0] count_q,
  output logic                  term_cnt
);
  localparam int unsigned CNT_W = SEG_W * SEGS;

  logic [SEGS-1:0] sec_full;
  logic [SEGS-1:0] sec_pre_full;
  logic [SEGS:0]   carry_q;
  logic [SEGS:0]   carry_d;

  // Section 0 steps on every enabled cycle.
  assign carry_q[0] = 1'b1;
  assign carry_d[0] = 1'b1;

  for (genvar i = 0; i < SEGS; i++) begin : g_sec
    seg_cnt_section #(.SEG_W(SEG_W)) u_sec (
      .clk         (clk),
      .rst         (rst),
      .en          (cnt_en),
      .carry_in    (carry_q[i]),
      .val         (count_q[i*SEG_W +: SEG_W]),
      .at_full     (sec_full[i]),
      .at_pre_full (sec_pre_full[i])
    );
  end

  for (genvar i = 1; i <= SEGS; i++) begin : g_carry
    logic ok;
    if (i == 1) begin : g_first
      assign ok = sec_pre_full[0];
    end else begin : g_rest
      assign ok = sec_full[i-1];
    end
    seg_cnt_carry u_carry (
      .clk      (clk),
      .rst      (rst),
      .en       (cnt_en),
      .chain_in (carry_d[i-1]),
      .local_ok (ok),
      .carry_d  (carry_d[i]),
      .carry_q  (carry_q[i])
    );

    // Each registered carry must agree with the bits below it.
    p_carry_aligned_r4: assert property (@(posedge clk) disable iff (rst)
      carry_q[i] == (&count_q[i*SEG_W-1:0]));
  end

  assign term_cnt = carry_q[SEGS];

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (count_q == '0) && !term_cnt);

  p_tc_r5: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (&count_q));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (term_cnt && cnt_en) |=> (count_q == '0) && !term_cnt);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_q) && $stable(term_cnt));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> (count_q == CNT_W'($past(count_q) + 1'b1)));

endmodule

// File: tb/seg_counter_bench.sv
module seg_counter_bench;
  localparam int unsigned BW = 32;
  localparam int unsigned SW = 12;

  typedef struct packed {
    logic [BW-1:0] big;
    logic          big_tc;
    logic [SW-1:0] sml;
    logic          sml_tc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [BW-1:0] big_q;
  logic          big_tc;
  logic [SW-1:0] sml_q;
  logic          sml_tc;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [BW-1:0] ref_big = '0;
  logic [SW-1:0] ref_sml = '0;
  logic          prev_en = 1'b0;
  logic          prev_rst = 1'b1;

  always #2 clk = ~clk;

  seg_counter u_seg_counter (
    .clk(clk), .rst(rst), .cnt_en(en), .count_q(big_q), .term_cnt(big_tc));

  seg_counter #(.SEG_W(3), .SEGS(4)) u_seg_counter_small (
    .clk(clk), .rst(rst), .cnt_en(en), .count_q(sml_q), .term_cnt(sml_tc));

  // Driver: drives one cycle and pushes what the next edge must give.
  task automatic step(input logic r, input logic e);
    string t;
    exp_t  x;
    @(negedge clk);
    rst = r;
    en  = e;
    if (r)                                  t = (prev_en && !prev_rst) ? "R7" : "R1";
    else if (!e)                            t = (ref_sml[2:0] == 3'b111) ? "R8" : "R3";
    else if (&ref_sml)                      t = "R6";
    else if (!prev_en && ref_sml[2:0] == 3'b111) t = "R8";
    else if (&(ref_sml + 12'd1))            t = "R5";
    else if (ref_sml[2:0] == 3'b111 || ref_big[7:0] == 8'hFF) t = "R4";
    else                                    t = "R2";
    if (r) begin
      ref_big = '0;
      ref_sml = '0;
    end else if (e) begin
      ref_big = ref_big + 32'd1;
      ref_sml = ref_sml + 12'd1;
    end
    x.big    = ref_big;
    x.big_tc = &ref_big;
    x.sml    = ref_sml;
    x.sml_tc = &ref_sml;
    exp_q.push_back(x);
    tag_q.push_back(t);
    prev_en  = e;
    prev_rst = r;
  endtask

  // Monitor: compares just after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t  x;
      string t;
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (big_q !== x.big) begin
        failures++;
        $display("FAIL %s wide count actual=%h expected=%h", t, big_q, x.big);
      end
      checks++;
      if (big_tc !== x.big_tc) begin
        failures++;
        $display("FAIL %s wide term actual=%b expected=%b", t, big_tc, x.big_tc);
      end
      checks++;
      if (sml_q !== x.sml) begin
        failures++;
        $display("FAIL %s narrow count actual=%h expected=%h", t, sml_q, x.sml);
      end
      checks++;
      if (sml_tc !== x.sml_tc) begin
        failures++;
        $display("FAIL %s narrow term actual=%b expected=%b", t, sml_tc, x.sml_tc);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      checks++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) step(1'b1, 1'b0);
    // R2/R4: steady counting across the low section boundaries
    repeat (600) step(1'b0, 1'b1);
    // R3/R8: random enable gaps, narrow counter wraps (R6)
    for (int k = 0; k < 9000; k++) step(1'b0, ($urandom % 4) != 0);
    // R8: pause exactly when the low narrow section is all ones
    while (ref_sml[2:0] != 3'b110) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    repeat (4) step(1'b0, 1'b0);
    repeat (10) step(1'b0, 1'b1);
    // R5/R6/R8: stop on all ones, hold, then wrap
    while (ref_sml != 12'hFFE) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    repeat (3) step(1'b0, 1'b0);
    repeat (5) step(1'b0, 1'b1);
    // R7: reset while counting with enable high
    repeat (20) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    repeat (10) step(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule